// File: doc/BRIEF.md
# Programmable Delay Line and Circular Buffer

This block holds a stream of 10-bit words for a programmable number of clock cycles. Every word passes through an input register, then a variable delay kept in a single-port style RAM, then an output register. The RAM length is set by an 11-bit length value. Because the two registers always add two cycles, the value held is the wanted total latency minus two. Useful settings run from 0 to 1279, which gives 2 to 1281 cycles in total.

A mode input turns the delay line into a ring. In recirculate mode the external data input is ignored and the output register feeds the input register. The stored words then circulate with a period equal to the total latency. A clock enable freezes every register, the length value, the address pointer and the RAM contents. An output enable sends the data output to high impedance, as a bus driver would.

Top module: `pdelay_ring`

## Requirements
- R1: In delay mode (`mode`=0) with length value N from 1 to 1279, a word on `din` at enabled edge k is on `dout` after enabled edge k+N+1, so the total latency is N+2 cycles.
- R2: With length value 0 the RAM is bypassed. A word on `din` at enabled edge k is on `dout` after enabled edge k+1, so the total latency is 2.
- R3: When `len_we` and `ce` are both high at a rising edge, `len_in` is loaded into the length register. It sets the latency of every word accepted from the following edge on.
- R4: A `len_in` value above 1279 loads as 1279, which gives a latency of 1281 cycles.
- R5: With `mode`=1 at an enabled edge, the input register takes the output register value and `din` is ignored. Once all words accepted in delay mode have drained, `dout` after enabled edge e equals `dout` after enabled edge e-(N+2).
- R6: While `ce` is low, no register, pointer, length value or RAM word changes. `dout` stays constant and a `len_we` pulse has no effect.
- R7: With `oe` low, every bit of `dout` is high impedance. With `oe` high, `dout` carries the output register.
- R8: Synchronous active-high `rst` clears the input and output registers, the pointer and the length register (length value 0). `dout` reads 0 after reset while `oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; low freezes all state |
| mode | input | 1 | 0 = delay line, 1 = recirculate |
| len_we | input | 1 | Load strobe for the length register |
| len_in | input | 11 | New length value (total latency minus 2) |
| din | input | 10 | Data word in |
| oe | input | 1 | Output enable; low gives high impedance |
| dout | output | 10 | Data word out |

## Verification
With length value N, the output seen after enabled edge k+N+1 must match the word driven before edge k. The bench drives inputs on the falling edge and samples `dout` on the next falling edge, so each sample reflects exactly one more rising edge. It counts only enabled edges when it computes which word is due, and edges with `ce` low must leave the previous sample unchanged. In recirculate mode the expected sample for edge e is built from the delay-mode words when e-N-1 lies before the mode switch, and from the expected sample for edge e-(N+2) when it does not.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int unsigned PDR_DATA_W = 10;
  localparam int unsigned PDR_LEN_W  = 11;
  localparam int unsigned PDR_DEPTH  = 1280;

  typedef enum logic {
    MODE_DELAY  = 1'b0,
    MODE_RECIRC = 1'b1
  } pdr_mode_e;
endpackage

// File: rtl/pdr_len_ctrl.sv
module pdr_len_ctrl #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned DEPTH = 1280
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_in,
  output logic [LEN_W-1:0] len_q
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH - 1);

  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    len_clamped = (len_in > LEN_MAX) ? LEN_MAX : len_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (ce && len_we) begin
      len_q <= len_clamped;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_MAX); // R4
  AST_LEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ce && len_we && len_in <= LEN_MAX) |=> (len_q == $past(len_in))); // R3
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(len_q)); // R6
endmodule

// File: rtl/pdr_addr_seq.sv
module pdr_addr_seq #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned DEPTH = 1280,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [LEN_W-1:0] len_q,
  output logic [PTR_W-1:0] ptr_q
);
  logic at_end;

  always_comb begin
    at_end = (len_q == '0) || (LEN_W'(ptr_q) >= (len_q - LEN_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ce) begin
      ptr_q <= at_end ? '0 : ptr_q + PTR_W'(1);
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ce && len_q != '0 && LEN_W'(ptr_q) >= len_q - LEN_W'(1)) |=> (ptr_q == '0)); // R1
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/pdr_ring_ram.sv
module pdr_ring_ram #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned DEPTH  = 1280,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              bypass;

  always_comb begin
    bypass = (len_q == '0);
  end

  // Write port: the newest word replaces the oldest one at the pointer.
  always_ff @(posedge clk) begin
    if (ce && !bypass) begin
      mem[ptr_q] <= wr_data;
    end
  end

  // Read port doubles as the output register (read-before-write).
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (ce) begin
      out_q <= bypass ? wr_data : mem[ptr_q];
    end
  end

  AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (rst)
    (ce && len_q == '0) |=> (out_q == $past(wr_data))); // R2
endmodule

// File: rtl/pdelay_ring.sv
module pdelay_ring
  import pdr_pkg::*;
#(
  parameter int unsigned DATA_W = PDR_DATA_W,
  parameter int unsigned LEN_W  = PDR_LEN_W,
  parameter int unsigned DEPTH  = PDR_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              mode,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dout
);
  pdr_mode_e         mode_sel;
  logic [LEN_W-1:0]  len_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] in_next;

  always_comb begin
    mode_sel = pdr_mode_e'(mode);
    in_next  = (mode_sel == MODE_RECIRC) ? out_q : din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
    end else if (ce) begin
      in_q <= in_next;
    end
  end

  pdr_len_ctrl #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_len (
    .clk(clk), .rst(rst), .ce(ce), .len_we(len_we), .len_in(len_in), .len_q(len_q)
  );

  pdr_addr_seq #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst(rst), .ce(ce), .len_q(len_q), .ptr_q(ptr_q)
  );

  pdr_ring_ram #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .ce(ce), .len_q(len_q), .ptr_q(ptr_q),
    .wr_data(in_q), .out_q(out_q)
  );

  assign dout = oe ? out_q : {DATA_W{1'bz}};

  AST_RECIRC_FEED: assert property (@(posedge clk) disable iff (rst)
    (ce && mode) |=> (in_q == $past(out_q))); // R5
  AST_DELAY_FEED: assert property (@(posedge clk) disable iff (rst)
    (ce && !mode) |=> (in_q == $past(din))); // R1
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(out_q) && $stable(in_q))); // R6
endmodule

// File: tb/test_pdelay_ring.sv
module test_pdelay_ring;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic        mode = 1'b0;
  logic        len_we = 1'b0;
  logic [10:0] len_in = '0;
  logic [9:0]  din = '0;
  logic        oe = 1'b1;
  wire  [9:0]  dout_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  for (genvar b = 0; b < 10; b++) begin : g_pull
    pullup (dout_w[b]);
  end

  pdelay_ring i_pdelay_ring (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode), .len_we(len_we),
    .len_in(len_in), .din(din), .oe(oe), .dout(dout_w)
  );

  function automatic logic [9:0] word(int c, int seed);
    return 10'((c * 37 + seed) % 1021);
  endfunction

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_len(int v);
    len_in = 11'(v);
    len_we = 1'b1;
    step();
    len_we = 1'b0;
  endtask

  // R8 and R7: reset state and output enable
  task automatic t_reset_oe();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    check("R8", dout_w, 10'h000);
    oe = 1'b0;
    #1;
    check("R7", dout_w, 10'h3FF);
    oe = 1'b1;
    #1;
    check("R7", dout_w, 10'h000);
  endtask

  // R1 R2 R3 R4: delay mode latency for a programmed value
  task automatic t_delay(string req, int prog, int eff, int seed);
    mode = 1'b0;
    load_len(prog);
    for (int c = 0; c <= eff + 9; c++) begin
      din = word(c, seed);
      step();
      if (c >= eff + 1) check(req, dout_w, word(c - eff - 1, seed));
    end
  endtask

  // R5: ring operation with length value 3, period 5
  task automatic t_recirc();
    localparam int N = 3;
    localparam int L = N + 2;
    localparam int SW = 12;
    logic [9:0] exp_q [0:40];
    mode = 1'b0;
    load_len(N);
    for (int c = 0; c <= SW + 3 * L; c++) begin
      mode = (c >= SW);
      din  = (c < SW) ? word(c, 11) : (10'h155 ^ 10'(c));
      step();
      if (c - N - 1 >= 0) begin
        if (c - N - 1 < SW) exp_q[c] = word(c - N - 1, 11);
        else exp_q[c] = exp_q[c - L];
        check("R5", dout_w, exp_q[c]);
      end
    end
    mode = 1'b0;
  endtask

  // R6: clock enable gaps, with a length load attempted while frozen
  task automatic t_freeze();
    int en = 0;
    logic [9:0] prev;
    localparam int N = 2;
    mode = 1'b0;
    load_len(N);
    prev = dout_w;
    for (int c = 0; c < 32; c++) begin
      ce = (c % 5) != 3;
      len_we = !ce;
      len_in = 11'd7;
      din = ce ? word(en, 5) : 10'h2AA;
      step();
      if (ce) begin
        if (en >= N + 1) check("R6", dout_w, word(en - N - 1, 5));
        en++;
      end else begin
        check("R6", dout_w, prev);
      end
      prev = dout_w;
    end
    ce = 1'b1;
    len_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_oe();
    t_delay("R2", 0, 0, 3);
    t_delay("R1", 1, 1, 7);
    t_delay("R3", 5, 5, 9);
    t_delay("R1", 1279, 1279, 13);
    t_delay("R4", 2000, 1279, 17);
    t_recirc();
    t_freeze();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule